// File: doc/BRIEF.md
# Extended-Precision Round-to-Integer Unit

This unit takes one floating-point operand in the 80-bit extended format and rounds it to an integral value in the same format. The format has a sign bit, a 15-bit biased exponent (bias 16383) and a 64-bit significand whose top bit is an explicit integer bit. A 2-bit rounding-control input selects the direction for each operation. Alongside the result, the unit reports whether the magnitude was incremented, and it raises four exception flags: stack underflow, invalid operation, denormal operand and inexact result.

A host datapath presents an operand with a valid strobe, the rounding-control field and an indication that the source stack slot is empty. One clock later the unit returns the result with its own valid strobe. Infinities, NaNs, zeros, denormals and encodings the format does not support each follow their own rule. Every output is registered. The output registers keep their value between operations.

Top module: `rti_unit`

## Requirements
- R1: `out_valid` is high exactly one clock cycle after each cycle in which `in_valid` is high, and low otherwise.
- R2: Rounding control 00 rounds to nearest. An exact tie goes to the even integer.
- R3: Rounding control 01 rounds toward minus infinity, 10 rounds toward plus infinity and 11 rounds toward zero.
- R4: For a finite, supported operand with the stack present, `flag_inexact` is high exactly when the operand has a nonzero fractional part.
- R5: `rnd_up` is high exactly when the magnitude of the result is larger than the operand's truncated magnitude. It is never high without `flag_inexact`.
- R6: If the increment carries out of the significand, the result significand becomes 0x8000_0000_0000_0000 and the exponent goes up by one.
- R7: An operand whose magnitude is below 1 gives either a zero of the operand's sign or 1.0 of the operand's sign (exponent 16383, significand 0x8000_0000_0000_0000).
- R8: A normal operand with a biased exponent of 16383+63 or more, or a zero of either sign, is returned unchanged with no flags raised and `rnd_up` low.
- R9: An infinity (exponent all ones, significand 0x8000_0000_0000_0000) is returned unchanged with no flags raised.
- R10: A quiet NaN (exponent all ones, significand bits 63 and 62 set) is returned unchanged with no flags. A signaling NaN (bit 63 set, bit 62 clear, rest nonzero) is returned with bit 62 set and raises `flag_invalid` alone.
- R11: An unsupported encoding is any operand with a nonzero exponent and a clear integer bit, including an all-ones exponent. Such an operand raises `flag_invalid` alone and returns the default NaN: sign 1, exponent all ones, significand 0xC000_0000_0000_0000.
- R12: A denormal operand (exponent zero, significand nonzero) raises `flag_denormal`. It is rounded as a value below 1 and also raises `flag_inexact`.
- R13: While `stack_empty` is high, the operation raises `flag_underflow` alone, forces `rnd_up` low and returns the default NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 80 | Source value: sign, 15-bit exponent, 64-bit significand |
| rc | input | 2 | Rounding control: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| stack_empty | input | 1 | Source slot holds no value |
| out_valid | output | 1 | Result present this cycle |
| result | output | 80 | Rounded value |
| rnd_up | output | 1 | Magnitude was incremented by rounding |
| flag_underflow | output | 1 | Stack underflow |
| flag_invalid | output | 1 | Signaling NaN or unsupported encoding |
| flag_denormal | output | 1 | Operand was denormal |
| flag_inexact | output | 1 | Operand was not integral |

## Verification
The bench builds the unit with its default widths: a 15-bit exponent and a 64-bit significand. Only with these widths does the integral threshold sit at an unbiased exponent of 63. The bench can then drive the last exponent that still has a single fraction bit, and the first one at which every value passes through. The full-width significand also allows all-ones integer parts that carry into the next exponent, and denormals whose single set bit sits at the very bottom of the word.

// File: rtl/rti_pkg.sv
package rti_pkg;

    typedef enum logic [1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_ZERO = 2'b11
    } rc_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_DENORM,
        CL_NORMAL,
        CL_INF,
        CL_QNAN,
        CL_SNAN,
        CL_UNSUP
    } opclass_e;

    // Decide whether the truncated magnitude must be incremented.
    function automatic logic rnd_inc(rc_e mode, logic sign, logic lsb,
                                     logic rbit, logic sticky);
        logic lost;
        lost = rbit | sticky;
        unique case (mode)
            RC_NEAR: rnd_inc = rbit & (sticky | lsb);
            RC_DOWN: rnd_inc = sign & lost;
            RC_UP:   rnd_inc = ~sign & lost;
            default: rnd_inc = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rti_classify.sv
module rti_classify
    import rti_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] sig_i,
    output opclass_e         cls_o
);

    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

    logic int_bit;
    logic quiet_bit;
    logic low_nz;

    assign int_bit   = sig_i[MAN_W-1];
    assign quiet_bit = sig_i[MAN_W-2];
    assign low_nz    = |sig_i[MAN_W-2:0];

    always_comb begin
        if (exp_i == '0) begin
            cls_o = (sig_i == '0) ? CL_ZERO : CL_DENORM;
        end else if (!int_bit) begin
            cls_o = CL_UNSUP;
        end else if (exp_i == EXP_ONES) begin
            if (!low_nz)
                cls_o = CL_INF;
            else if (quiet_bit)
                cls_o = CL_QNAN;
            else
                cls_o = CL_SNAN;
        end else begin
            cls_o = CL_NORMAL;
        end
    end

endmodule

// File: rtl/rti_round_core.sv
module rti_round_core
    import rti_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64
) (
    input  logic             sign_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] sig_i,
    input  rc_e              mode_i,
    output logic [EXP_W-1:0] exp_o,
    output logic [MAN_W-1:0] sig_o,
    output logic             inc_o,
    output logic             inexact_o
);

    localparam logic [EXP_W-1:0] BIAS_V  = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] INT_LIM = BIAS_V + EXP_W'(MAN_W - 1);
    localparam logic [MAN_W-1:0] ONE_SIG = {1'b1, {(MAN_W-1){1'b0}}};

    logic [EXP_W-1:0] fcnt;
    logic [MAN_W-1:0] mask;
    logic [MAN_W-1:0] half;
    logic [MAN_W-1:0] trunc;
    logic [MAN_W:0]   sum;
    logic             rbit;
    logic             sticky;
    logic             lsb;
    logic             inc;

    // Number of fraction bits in the mid range (1 .. MAN_W-1).
    assign fcnt = INT_LIM - exp_i;
    assign mask = (MAN_W'(1) << fcnt) - MAN_W'(1);
    assign half = MAN_W'(1) << (fcnt - EXP_W'(1));
    assign trunc = sig_i & ~mask;

    always_comb begin
        exp_o     = exp_i;
        sig_o     = sig_i;
        inc_o     = 1'b0;
        inexact_o = 1'b0;
        rbit      = 1'b0;
        sticky    = 1'b0;
        lsb       = 1'b0;
        inc       = 1'b0;
        sum       = '0;
        if (exp_i >= INT_LIM) begin
            // Already integral: pass through.
        end else if (exp_i < BIAS_V) begin
            // Magnitude below one: result is zero or one.
            rbit      = (exp_i == BIAS_V - EXP_W'(1));
            sticky    = rbit ? (|sig_i[MAN_W-2:0]) : (|sig_i);
            inc       = rnd_inc(mode_i, sign_i, 1'b0, rbit, sticky);
            inc_o     = inc;
            inexact_o = rbit | sticky;
            exp_o     = inc ? BIAS_V : '0;
            sig_o     = inc ? ONE_SIG : '0;
        end else begin
            rbit      = |(sig_i & half);
            sticky    = |(sig_i & mask & ~half);
            lsb       = |(sig_i & (half << 1));
            inc       = rnd_inc(mode_i, sign_i, lsb, rbit, sticky);
            inc_o     = inc;
            inexact_o = rbit | sticky;
            sum       = {1'b0, trunc} + (inc ? {1'b0, half << 1} : '0);
            if (sum[MAN_W]) begin
                sig_o = ONE_SIG;
                exp_o = exp_i + EXP_W'(1);
            end else begin
                sig_o = sum[MAN_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rti_unit.sv
module rti_unit
    import rti_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] operand,
    input  logic [1:0]   rc,
    input  logic         stack_empty,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         rnd_up,
    output logic         flag_underflow,
    output logic         flag_invalid,
    output logic         flag_denormal,
    output logic         flag_inexact
);

    localparam logic [W-1:0] DEF_NAN =
        {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};
    localparam logic [W-1:0] QUIET_MASK = W'(1) << (MAN_W - 2);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] res;
        logic         up;
        logic         uf;
        logic         inv;
        logic         den;
        logic         inx;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic             op_sign;
    logic [EXP_W-1:0] op_exp;
    logic [MAN_W-1:0] op_sig;
    opclass_e         op_cls;
    logic [EXP_W-1:0] rnd_exp;
    logic [MAN_W-1:0] rnd_sig;
    logic             rnd_inc_w;
    logic             rnd_inx;

    assign op_sign = operand[W-1];
    assign op_exp  = operand[W-2 -: EXP_W];
    assign op_sig  = operand[MAN_W-1:0];

    rti_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) classify_i (
        .exp_i (op_exp),
        .sig_i (op_sig),
        .cls_o (op_cls)
    );

    rti_round_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) core_i (
        .sign_i    (op_sign),
        .exp_i     (op_exp),
        .sig_i     (op_sig),
        .mode_i    (rc_e'(rc)),
        .exp_o     (rnd_exp),
        .sig_o     (rnd_sig),
        .inc_o     (rnd_inc_w),
        .inexact_o (rnd_inx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res = operand;
            st_d.up  = 1'b0;
            st_d.uf  = 1'b0;
            st_d.inv = 1'b0;
            st_d.den = 1'b0;
            st_d.inx = 1'b0;
            if (stack_empty) begin
                st_d.res = DEF_NAN;
                st_d.uf  = 1'b1;
            end else begin
                unique case (op_cls)
                    CL_SNAN: begin
                        st_d.res = operand | QUIET_MASK;
                        st_d.inv = 1'b1;
                    end
                    CL_UNSUP: begin
                        st_d.res = DEF_NAN;
                        st_d.inv = 1'b1;
                    end
                    CL_NORMAL, CL_DENORM: begin
                        st_d.res = {op_sign, rnd_exp, rnd_sig};
                        st_d.up  = rnd_inc_w;
                        st_d.inx = rnd_inx;
                        st_d.den = (op_cls == CL_DENORM);
                    end
                    default: ; // zero, infinity, quiet NaN pass through
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.valid;
    assign result         = st_q.res;
    assign rnd_up         = st_q.up;
    assign flag_underflow = st_q.uf;
    assign flag_invalid   = st_q.inv;
    assign flag_denormal  = st_q.den;
    assign flag_inexact   = st_q.inx;

endmodule

// File: rtl/rti_unit_chk.sv
module rti_unit_chk #(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] operand,
    input logic         stack_empty,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         rnd_up,
    input logic         flag_underflow,
    input logic         flag_invalid,
    input logic         flag_denormal,
    input logic         flag_inexact
);

    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] INT_LIM  =
        {1'b0, {(EXP_W-1){1'b1}}} + EXP_W'(MAN_W - 1);

    logic big_int_op;
    assign big_int_op = in_valid && !stack_empty
                     && operand[W-2 -: EXP_W] >= INT_LIM
                     && operand[W-2 -: EXP_W] != EXP_ONES
                     && operand[MAN_W-1];

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R13
    underflow_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_underflow) |->
            (!rnd_up && !flag_invalid && !flag_denormal && !flag_inexact));

    // R5
    up_needs_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rnd_up) |-> flag_inexact);

    // R10
    invalid_gives_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |->
            (result[W-2 -: EXP_W] == EXP_ONES && result[MAN_W-2]
             && !rnd_up && !flag_inexact));

    // R8
    big_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        big_int_op |=> (result == $past(operand) && !flag_inexact && !rnd_up));

endmodule

bind rti_unit rti_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .operand        (operand),
    .stack_empty    (stack_empty),
    .out_valid      (out_valid),
    .result         (result),
    .rnd_up         (rnd_up),
    .flag_underflow (flag_underflow),
    .flag_invalid   (flag_invalid),
    .flag_denormal  (flag_denormal),
    .flag_inexact   (flag_inexact)
);

// File: tb/rti_unit_tb_top.sv
module rti_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [79:0] operand = '0;
    logic [1:0]  rc = 2'b00;
    logic        stack_empty = 1'b0;
    logic        out_valid;
    logic [79:0] result;
    logic        rnd_up;
    logic        flag_underflow;
    logic        flag_invalid;
    logic        flag_denormal;
    logic        flag_inexact;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] NEAR = 2'b00, DOWN = 2'b01, UP = 2'b10, TZ = 2'b11;
    localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;
    localparam logic [79:0] DEF_NAN = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

    always #(CLK_PERIOD/2) clk = ~clk;

    rti_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .operand        (operand),
        .rc             (rc),
        .stack_empty    (stack_empty),
        .out_valid      (out_valid),
        .result         (result),
        .rnd_up         (rnd_up),
        .flag_underflow (flag_underflow),
        .flag_invalid   (flag_invalid),
        .flag_denormal  (flag_denormal),
        .flag_inexact   (flag_inexact)
    );

    function automatic logic [79:0] fp(input logic s, input logic [14:0] e,
                                       input logic [63:0] m);
        return {s, e, m};
    endfunction

    task automatic check(input string tag, input logic [79:0] got,
                         input logic [79:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // flags order: {underflow, invalid, denormal, inexact}
    task automatic run(input string tag, input logic [79:0] op,
                       input logic [1:0] mode, input logic emp,
                       input logic [79:0] eres, input logic eup,
                       input logic [3:0] eflg);
        @(negedge clk);
        in_valid    = 1'b1;
        operand     = op;
        rc          = mode;
        stack_empty = emp;
        @(negedge clk);
        in_valid    = 1'b0;
        stack_empty = 1'b0;
        check({tag, " valid"}, 80'(out_valid), 80'(1'b1));
        check({tag, " result"}, result, eres);
        check({tag, " rnd_up"}, 80'(rnd_up), 80'(eup));
        check({tag, " flags"},
              80'({flag_underflow, flag_invalid, flag_denormal, flag_inexact}),
              80'(eflg));
    endtask

    task automatic t_reset;
        check("R1 reset valid", 80'(out_valid), 80'(1'b0));
        check("R1 reset flags",
              80'({rnd_up, flag_underflow, flag_invalid, flag_denormal, flag_inexact}),
              80'(0));
    endtask

    task automatic t_nearest;
        run("R2 2.5 tie even", fp(0, 15'h4000, 64'hA000_0000_0000_0000), NEAR, 0,
            fp(0, 15'h4000, ONE), 0, 4'b0001);
        run("R2 1.25 down", fp(0, 15'h3FFF, 64'hA000_0000_0000_0000), NEAR, 0,
            fp(0, 15'h3FFF, ONE), 0, 4'b0001);
        run("R2 e62 odd tie", fp(0, 15'h403D, 64'h8000_0000_0000_0003), NEAR, 0,
            fp(0, 15'h403D, 64'h8000_0000_0000_0004), 1, 4'b0001);
    endtask

    task automatic t_directed;
        run("R3 2.5 up", fp(0, 15'h4000, 64'hA000_0000_0000_0000), UP, 0,
            fp(0, 15'h4000, 64'hC000_0000_0000_0000), 1, 4'b0001);
        run("R3 2.5 down", fp(0, 15'h4000, 64'hA000_0000_0000_0000), DOWN, 0,
            fp(0, 15'h4000, ONE), 0, 4'b0001);
        run("R3 -2.5 down", fp(1, 15'h4000, 64'hA000_0000_0000_0000), DOWN, 0,
            fp(1, 15'h4000, 64'hC000_0000_0000_0000), 1, 4'b0001);
        run("R3 -2.5 up", fp(1, 15'h4000, 64'hA000_0000_0000_0000), UP, 0,
            fp(1, 15'h4000, ONE), 0, 4'b0001);
        run("R3 2.5 zero", fp(0, 15'h4000, 64'hA000_0000_0000_0000), TZ, 0,
            fp(0, 15'h4000, ONE), 0, 4'b0001);
    endtask

    task automatic t_carry;
        run("R6 3.5 near", fp(0, 15'h4000, 64'hE000_0000_0000_0000), NEAR, 0,
            fp(0, 15'h4001, ONE), 1, 4'b0001);
        run("R5 3.75 up carry", fp(0, 15'h4000, 64'hF000_0000_0000_0000), UP, 0,
            fp(0, 15'h4001, ONE), 1, 4'b0001);
    endtask

    task automatic t_tiny;
        run("R7 0.75 near", fp(0, 15'h3FFE, 64'hC000_0000_0000_0000), NEAR, 0,
            fp(0, 15'h3FFF, ONE), 1, 4'b0001);
        run("R7 -0.75 zero", fp(1, 15'h3FFE, 64'hC000_0000_0000_0000), TZ, 0,
            fp(1, 15'h0000, 64'h0), 0, 4'b0001);
        run("R7 0.5 near", fp(0, 15'h3FFE, ONE), NEAR, 0,
            fp(0, 15'h0000, 64'h0), 0, 4'b0001);
        run("R7 0.5 up", fp(0, 15'h3FFE, ONE), UP, 0,
            fp(0, 15'h3FFF, ONE), 1, 4'b0001);
        run("R7 -0.25 down", fp(1, 15'h3FFD, ONE), DOWN, 0,
            fp(1, 15'h3FFF, ONE), 1, 4'b0001);
    endtask

    task automatic t_integral;
        run("R4 5.0 exact", fp(0, 15'h4001, 64'hA000_0000_0000_0000), UP, 0,
            fp(0, 15'h4001, 64'hA000_0000_0000_0000), 0, 4'b0000);
        run("R8 e63 pass", fp(1, 15'h403E, 64'hFFFF_FFFF_FFFF_FFFF), UP, 0,
            fp(1, 15'h403E, 64'hFFFF_FFFF_FFFF_FFFF), 0, 4'b0000);
        run("R8 neg zero", fp(1, 15'h0000, 64'h0), DOWN, 0,
            fp(1, 15'h0000, 64'h0), 0, 4'b0000);
    endtask

    task automatic t_specials;
        run("R9 +inf", fp(0, 15'h7FFF, ONE), UP, 0,
            fp(0, 15'h7FFF, ONE), 0, 4'b0000);
        run("R10 qnan", fp(0, 15'h7FFF, 64'hC000_0000_0000_1234), NEAR, 0,
            fp(0, 15'h7FFF, 64'hC000_0000_0000_1234), 0, 4'b0000);
        run("R10 snan", fp(1, 15'h7FFF, 64'h8000_0000_0000_0001), NEAR, 0,
            fp(1, 15'h7FFF, 64'hC000_0000_0000_0001), 0, 4'b0100);
        run("R11 unnormal", fp(0, 15'h4000, 64'h4000_0000_0000_0000), NEAR, 0,
            DEF_NAN, 0, 4'b0100);
        run("R11 pseudo inf", fp(0, 15'h7FFF, 64'h0), NEAR, 0,
            DEF_NAN, 0, 4'b0100);
    endtask

    task automatic t_denorm;
        run("R12 denorm up", fp(0, 15'h0000, 64'h1), UP, 0,
            fp(0, 15'h3FFF, ONE), 1, 4'b0011);
        run("R12 denorm near", fp(1, 15'h0000, 64'h1), NEAR, 0,
            fp(1, 15'h0000, 64'h0), 0, 4'b0011);
    endtask

    task automatic t_empty;
        run("R13 empty", fp(0, 15'h4000, 64'hA000_0000_0000_0000), UP, 1,
            DEF_NAN, 0, 4'b1000);
    endtask

    task automatic t_valid_timing;
        @(negedge clk);
        check("R1 idle after op", 80'(out_valid), 80'(1'b0));
        @(negedge clk);
        check("R1 idle stays low", 80'(out_valid), 80'(1'b0));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nearest();
        t_directed();
        t_carry();
        t_tiny();
        t_integral();
        t_specials();
        t_denorm();
        t_empty();
        t_valid_timing();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule